// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a four-wire serial slave that gives an external master read and write access to a byte-wide register file. The master holds the active-low select low for one 16-bit frame. The frame carries a register address, a direction bit and a data byte. On a write, the block delivers a single-cycle write strobe with address and data once the whole frame has arrived. On a read, it presents the address to the register file, latches the returned byte, and shifts that byte out on the serial output.

The serial clock, data and select are not used as clocks. They are synchronised into the system clock domain and their edges are detected there, so the serial clock must run several times slower than the system clock (four system cycles per serial half period or more with the default two synchroniser stages). The register file sits outside the block and is expected to return read data combinationally for the address it is shown.

Top module: `spi_regport`

## Requirements
- R1: A frame is 16 bits. Bits 1 to 7 are the register address, most significant bit first. Bit 8 is the direction bit. Bits 9 to 16 are the data byte, most significant bit first.
- R2: A direction bit of 1 selects a write and a direction bit of 0 selects a read. A read frame never produces a write strobe.
- R3: The serial input is sampled on rising serial-clock edges. The serial output only changes on falling serial-clock edges.
- R4: A complete write frame produces exactly one write strobe, one system clock long, carrying the frame's address and data. It is issued after the 16th rising edge while select is still low.
- R5: The output enable is low except during the data phase of a read. It rises at the falling edge after the direction bit. It falls at the falling edge after the 16th bit, or when select goes high.
- R6: A high select resets the bit count. A frame cut short by select going high applies nothing, and the next frame is decoded from its first bit.
- R7: Read data is the register file's byte at the frame's address. It is latched at the falling edge after the direction bit and shifted out most significant bit first.
- R8: Serial-clock edges beyond the 16th within one select window are ignored. They produce no further strobe and do not re-enable the output.
- R9: After reset the write strobe and the output enable are both low.
- R10: Registers may be written in any address order. A write is visible to a read frame issued straight after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the master (sampled) |
| si | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Output enable for the serial output driver |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 7 | Write address |
| wr_data | output | 8 | Write data |
| rd_addr | output | 7 | Read address shown to the register file |
| rd_data | input | 8 | Byte returned by the register file |

## Verification
The bench aims at truncated frames. A design that committed a write before the 16th bit would corrupt a register that a later read-back shows unchanged. A design that failed to clear its count on a high select would decode the following frame misaligned, and the result would show up as wrong addresses or data. Frames padded past 16 clocks catch a counter that wraps: such a design would fire a second strobe or re-enable the output. Reads of the extreme addresses and of all-ones and all-zeros data expose bit-order and off-by-one-edge errors in the shift-out. Checking the output enable at every bit shows whether the driver turns on during the address phase or stays on after the frame.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants and helpers for the serial register-access slave.
// Assumes a fixed frame of address, one direction bit and one data byte.
package spi_regport_pkg;

    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FRAME_BITS = ADDR_W + 1 + DATA_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    // Direction encoding carried in the bit after the address.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Count value reached when the last address bit has been received.
    function automatic logic [CNT_W-1:0] addr_last_cnt();
        return CNT_W'(ADDR_W - 1);
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is independent; reset value is chosen per instance.
module spi_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later flops: let any metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
// Module: receive side of the frame. It counts rising serial-clock edges,
// captures address, direction and data, and issues the write strobe.
// Assumes sck_rise is a single-cycle pulse and that si_s and ss_s share
// the synchroniser depth of the serial clock.
module spi_frame_rx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              si_s,
    input  logic              ss_s,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dir_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] data_sh;
    logic              take_bit;

    assign take_bit = sck_rise && !ss_s && (bit_cnt != CNT_FULL);

    // Bit counter: cleared by a high select, saturates at a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_cnt <= '0;
        else if (ss_s)     bit_cnt <= '0;
        else if (take_bit) bit_cnt <= bit_cnt + 1'b1;
    end

    // Address shifter: collects the address bits, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh <= '0;
        end else if (take_bit && bit_cnt < CNT_DIR) begin
            addr_sh <= {addr_sh[ADDR_W-2:0], si_s};
        end
    end

    // Address hold: the completed address is frozen for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take_bit && bit_cnt == addr_last_cnt()) begin
            addr_q <= {addr_sh[ADDR_W-2:0], si_s};
        end
    end

    // Direction capture: the bit that follows the address.
    always_ff @(posedge clk) begin
        if (!rst_n)                              dir_q <= DIR_READ;
        else if (take_bit && bit_cnt == CNT_DIR) dir_q <= si_s;
    end

    // Data shifter: collects the data byte, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_sh <= '0;
        end else if (take_bit && bit_cnt > CNT_DIR) begin
            data_sh <= {data_sh[DATA_W-2:0], si_s};
        end
    end

    // Write strobe: one cycle after the last bit of a complete write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (take_bit && bit_cnt == CNT_LAST && dir_q == DIR_WRITE) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= {data_sh[DATA_W-2:0], si_s};
            end
        end
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL)
        else $error("bit count beyond frame length");

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en)
        else $error("write strobe longer than one cycle");

    assert_strobe_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(ss_s))
        else $error("write strobe without select held low");

    assert_sel_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (bit_cnt == '0))
        else $error("bit count not cleared by high select");

endmodule

// File: rtl/spi_so_tx.sv
// Module: transmit side. It latches the read byte at the falling edge after
// the direction bit and shifts it out on later falling edges.
// Assumes rd_data is valid for addr_q when that falling edge is seen.
module spi_so_tx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              ss_s,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              dir_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic              so,
    output logic              so_oe
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [DATA_W-1:0] tx_sh;
    logic              load_now;
    logic              shift_now;

    assign load_now  = sck_fall && !ss_s && bit_cnt == CNT_LOAD && dir_q == DIR_READ;
    assign shift_now = sck_fall && !ss_s && so_oe && bit_cnt > CNT_LOAD && bit_cnt < CNT_FULL;

    // Output shifter: load on the data-phase entry, then move one bit per fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (ss_s) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (load_now) begin
            so    <= rd_data[DATA_W-1];
            tx_sh <= {rd_data[DATA_W-2:0], 1'b0};
            so_oe <= 1'b1;
        end else if (shift_now) begin
            so    <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end else if (sck_fall && bit_cnt == CNT_FULL) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
        end
    end

    assert_oe_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !$past(ss_s))
        else $error("output enabled without select");

    assert_oe_rise_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall))
        else $error("output enable rose away from a falling edge");

    assert_so_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so))
        else $error("serial output moved without a falling edge");

endmodule

// File: rtl/spi_regport.sv
// Module: top of the serial register-access slave. It synchronises the
// serial pins, detects serial-clock edges and joins the receive and
// transmit sides. Assumes the serial clock half period spans at least
// STAGES + 2 system clocks.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              si,
    input  logic              ss_n,
    output logic              so,
    output logic              so_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    logic [2:0]        pins_s;
    logic              sck_s, si_s, ss_s;
    logic              sck_q;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              dir_q;

    spi_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ss_n, si, sck}),
        .q_sync  (pins_s)
    );

    assign sck_s = pins_s[0];
    assign si_s  = pins_s[1];
    assign ss_s  = pins_s[2];

    // Edge history: previous synchronised serial-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = sck_s && !sck_q;
    assign sck_fall = !sck_s && sck_q;

    spi_frame_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .si_s     (si_s),
        .ss_s     (ss_s),
        .bit_cnt  (bit_cnt),
        .addr_q   (addr_q),
        .dir_q    (dir_q),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    spi_so_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_fall (sck_fall),
        .ss_s     (ss_s),
        .bit_cnt  (bit_cnt),
        .dir_q    (dir_q),
        .rd_data  (rd_data),
        .so       (so),
        .so_oe    (so_oe)
    );

    assign rd_addr = addr_q;

    assert_read_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !wr_en)
        else $error("write strobe during a read data phase");

endmodule

// File: tb/sim_spi_regport.sv
// Bench: a driver task issues frames and queues expected write strobes;
// a monitor pops and compares them as the design emits strobes.
module sim_spi_regport;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       ss_n = 1'b1;
    logic       so, so_oe, wr_en;
    logic [6:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    logic [7:0]  regfile [128];
    logic [7:0]  model [128];
    logic [14:0] exp_q [$];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .ss_n(ss_n),
        .so(so), .so_oe(so_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign rd_data = regfile[rd_addr];

    // Monitor: applies each strobe to the register file and scores it.
    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            regfile[wr_addr] <= wr_data;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected strobe: actual %h/%h expected none", wr_addr, wr_data);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if (e != {wr_addr, wr_data}) begin
                    fails++;
                    $display("FAIL R1 strobe: actual %h/%h expected %h/%h",
                             wr_addr, wr_data, e[14:8], e[7:0]);
                end
            end
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one select window with nbits serial clocks.
    task automatic frame(input logic [6:0] a, input logic dir, input logic [7:0] d,
                         input int nbits, output logic [7:0] got);
        logic [15:0] word;
        int oe_err;
        word = {a, dir, d};
        got = '0;
        oe_err = 0;
        if (dir && nbits >= 16) begin
            exp_q.push_back({a, d});
            model[a] = d;
        end
        ss_n = 1'b0;
        half();
        for (int i = 0; i < nbits; i++) begin
            si = (i < 16) ? word[15-i] : i[0];
            half();
            if (i >= 8 && i < 16 && !dir) begin
                got = {got[6:0], so};
                if (!so_oe) oe_err++;
            end else if (so_oe) begin
                oe_err++;
            end
            sck = 1'b1;
            half();
            sck = 1'b0;
        end
        half();
        half();
        if (!(dir == 1'b0 && nbits > 8 && nbits < 16) && so_oe) oe_err++;
        chk(oe_err == 0, "R5 enable window", oe_err, 0);
        ss_n = 1'b1;
        half();
        half();
        chk(!so_oe, "R6 enable after select high", so_oe, 0);
        chk(exp_q.size() == 0, "R4 strobe delivered", exp_q.size(), 0);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] g;
        frame(a, 1'b1, d, 16, g);
    endtask

    task automatic rd_check(input logic [6:0] a, input int nbits, input string req);
        logic [7:0] g;
        frame(a, 1'b0, 8'h00, nbits, g);
        chk(g == model[a], req, g, model[a]);
    endtask

    initial begin
        logic [7:0] g;
        for (int i = 0; i < 128; i++) begin
            regfile[i] = 8'(i * 3 + 5);
            model[i]   = 8'(i * 3 + 5);
        end
        repeat (5) @(negedge clk);
        chk(!wr_en, "R9 strobe in reset", wr_en, 0);
        chk(!so_oe, "R9 enable in reset", so_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!wr_en && !so_oe, "R9 idle after reset", {wr_en, so_oe}, 0);

        // R1 R2 R10: writes in a scattered address order
        wr(7'h7F, 8'h3C);
        wr(7'h00, 8'hA5);
        wr(7'h55, 8'h00);
        wr(7'h2A, 8'hFF);
        // R3 R7: read-back, most significant bit first
        rd_check(7'h00, 16, "R7 read 00");
        rd_check(7'h7F, 16, "R7 read 7F");
        rd_check(7'h2A, 16, "R3 R7 read 2A");
        rd_check(7'h55, 16, "R7 read 55");
        rd_check(7'h11, 16, "R2 read unwritten 11");
        // R10: write then immediate read
        wr(7'h33, 8'h96);
        rd_check(7'h33, 16, "R10 read after write");
        // R6: truncated write applies nothing
        frame(7'h2A, 1'b1, 8'h99, 12, g);
        rd_check(7'h2A, 16, "R6 after cut write");
        frame(7'h2A, 1'b1, 8'h99, 15, g);
        rd_check(7'h2A, 16, "R6 after 15-bit write");
        // R6: truncated read, then a full read decodes cleanly
        frame(7'h55, 1'b0, 8'h00, 10, g);
        rd_check(7'h7F, 16, "R6 read after cut read");
        // R8: extra clocks ignored
        frame(7'h40, 1'b1, 8'h81, 20, g);
        rd_check(7'h40, 20, "R8 padded read");
        rd_check(7'h40, 16, "R8 single write applied");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule